// File: doc/BRIEF.md
# Watchdog Timer Reset Generator

This block watches for firmware that has stopped running. A small counter moves forward on each periodic tick strobe taken from a free-running timer. Firmware must keep clearing the counter by writing to a dedicated clear address. Any data value clears it, and the location cannot be read back. If the clears stop, the tick that sets the counter's most significant bit raises a system reset.

The reset is held for a fixed number of half-tick strobes and then released. The block also does two other things when it fires. It sets a sticky cause flag that firmware reads after restart to learn why the reset happened. It gives a one-cycle pulse that clears the device-address register of an attached bus interface, which silences that interface's transmitter until firmware programs an address with its top bit set.

The block has an asynchronous active-low power-on reset. That reset is released synchronously inside the block.

Top module: `wdog_rst_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sys_rst_o`, `cause_flag_o` and `addr_clr_o` are 0 and the counter is 0. Power-on reset is the only thing besides a status write that clears the cause flag.
- R2: A write (`wr_en_i` = 1) to address `CLR_ADDR` (default 8'h26) sets the counter to zero whatever the data is. A write to any other address does not touch the counter.
- R3: Each cycle with `tick_i` = 1 adds one to the counter. `sys_rst_o` rises at the clock edge where a tick would take the counter's most significant bit from 0 to 1.
- R4: With `H` = 2^(`CNT_W`-1) and a tick period of `P` cycles, `sys_rst_o` rises no less than (H-1)*P+1 and no more than H*P cycles after the edge that took the last clear write. The same window applies after the edge that released a watchdog reset.
- R5: `sys_rst_o` stays high until the edge of the `RST_LEN`-th `half_tick_i` strobe after the edge where it rose. A strobe in the rising cycle itself is not counted. It falls at that edge.
- R6: `cause_flag_o` becomes 1 at the same edge as `sys_rst_o` rises. Later watchdog resets leave it at 1.
- R7: `addr_clr_o` is high for exactly one cycle, the first cycle in which `sys_rst_o` is high.
- R8: While `sys_rst_o` is high, the counter is held at zero and every register write is ignored. Counting starts again from zero when the reset releases.
- R9: A write to `STAT_ADDR` (default 8'hFF) loads `cause_flag_o` from data bit `CAUSE_BIT` (default 6). If a watchdog firing happens in the same cycle, the firing wins.
- R10: If a clear write and a tick arrive in the same cycle, the clear wins. The counter ends at zero and no reset fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | One-cycle strobe, once per watchdog tick period |
| half_tick_i | input | 1 | One-cycle strobe, twice per tick period, aligned with `tick_i` |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| sys_rst_o | output | 1 | Watchdog system reset, active high |
| cause_flag_o | output | 1 | Sticky flag: the last reset came from the watchdog |
| addr_clr_o | output | 1 | One-cycle pulse that clears the bus device-address register |

## Verification
The bench builds the block with `CNT_W` = 2 and `RST_LEN` = 3. It drives a tick every 8 clocks and a half-tick every 4 clocks. With these values a missed clear fires within 16 clocks. The reset width has to count three half-tick strobes, so the width counter steps beyond its first value and the writes placed inside the pulse fall where they must be ignored. The two-bit counter keeps the firing point at the single 01-to-10 step, which the timing window checks pin down from both ends.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_CLEAR  = 2'd1,
    WR_STATUS = 2'd2
  } wr_kind_e;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_tick_cnt.sv
module wdog_tick_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  // value one step below the top bit being set
  localparam logic [CNT_W-1:0] ARM = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             fire;

  always_comb begin
    fire   = tick_i & ~clr_i & ~hold_i & (cnt_q == ARM);
    cnt_en = hold_i | clr_i | tick_i;
    cnt_d  = cnt_q;
    if (hold_i || clr_i || fire) cnt_d = '0;
    else if (tick_i)             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire;
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int RST_LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic half_i,
  output logic active_o,
  output logic start_o
);
  localparam int LEN_W = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
  localparam logic [LEN_W-1:0] LAST = LEN_W'(RST_LEN - 1);

  logic             active_q, active_d;
  logic [LEN_W-1:0] hc_q, hc_d;
  logic             start_q, start_d;
  logic             hc_en;

  always_comb begin
    active_d = active_q;
    hc_d     = hc_q;
    hc_en    = 1'b0;
    start_d  = fire_i & ~active_q;
    if (active_q) begin
      if (half_i) begin
        hc_en = 1'b1;
        if (hc_q == LAST) active_d = 1'b0;
        else              hc_d     = hc_q + 1'b1;
      end
    end else if (fire_i) begin
      active_d = 1'b1;
      hc_d     = '0;
      hc_en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      start_q  <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hc_q <= '0;
    else if (hc_en) hc_q <= hc_d;
  end

  assign active_o = active_q;
  assign start_o  = start_q;
endmodule

// File: rtl/wdog_cause_flag.sv
module wdog_cause_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | wr_i;
    flag_d  = set_i ? 1'b1 : wbit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen
  import wdog_pkg::*;
#(
  parameter int          CNT_W       = 2,
  parameter int          RST_LEN     = 1,
  parameter int          AW          = 8,
  parameter int          DW          = 8,
  parameter logic [AW-1:0] CLR_ADDR  = 8'h26,
  parameter logic [AW-1:0] STAT_ADDR = 8'hFF,
  parameter int          CAUSE_BIT   = 6,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          half_tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          sys_rst_o,
  output logic          cause_flag_o,
  output logic          addr_clr_o
);
  logic             rst_sync_n;
  wr_kind_e         wr_kind;
  logic             fire;
  logic             rst_act;
  logic [CNT_W-1:0] wdt_cnt;
  logic             data_unused;

  assign data_unused = ^wr_data_i;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // writes decode only while the watchdog reset is not held
  always_comb begin
    wr_kind = WR_NONE;
    if (wr_en_i && !rst_act) begin
      if (wr_addr_i == CLR_ADDR)       wr_kind = WR_CLEAR;
      else if (wr_addr_i == STAT_ADDR) wr_kind = WR_STATUS;
    end
  end

  wdog_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_i (tick_i),
    .clr_i  (wr_kind == WR_CLEAR),
    .hold_i (rst_act),
    .cnt_o  (wdt_cnt),
    .fire_o (fire)
  );

  wdog_rst_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fire_i   (fire),
    .half_i   (half_tick_i),
    .active_o (rst_act),
    .start_o  (addr_clr_o)
  );

  wdog_cause_flag u_cause (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (fire),
    .wr_i   (wr_kind == WR_STATUS),
    .wbit_i (wr_data_i[CAUSE_BIT]),
    .flag_o (cause_flag_o)
  );

  assign sys_rst_o = rst_act;
endmodule

// File: rtl/wdog_rst_gen_chk.sv
module wdog_rst_gen_chk #(
  parameter int            CNT_W     = 2,
  parameter int            AW        = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'hFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             half_tick_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic             sys_rst_o,
  input logic             cause_flag_o,
  input logic             addr_clr_o,
  input logic [CNT_W-1:0] wdt_cnt
);
  localparam logic [CNT_W-1:0] ARM = {1'b0, {(CNT_W-1){1'b1}}};

  p_fire_at_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> ($past(tick_i) && $past(wdt_cnt) == ARM));

  p_msb_never_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_cnt[CNT_W-1]);

  p_held_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (wdt_cnt == '0));

  p_release_on_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> $past(half_tick_i));

  p_cause_on_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> cause_flag_o);

  p_clr_with_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> addr_clr_o);

  p_clr_only_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr_o |-> $rose(sys_rst_o));

  p_flag_drop_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cause_flag_o) |-> $past(wr_en_i && wr_addr_i == STAT_ADDR && !sys_rst_o));
endmodule

bind wdog_rst_gen wdog_rst_gen_chk #(
  .CNT_W(CNT_W), .AW(AW), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tick_i       (tick_i),
  .half_tick_i  (half_tick_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .sys_rst_o    (sys_rst_o),
  .cause_flag_o (cause_flag_o),
  .addr_clr_o   (addr_clr_o),
  .wdt_cnt      (wdt_cnt)
);

// File: tb/wdog_rst_gen_bench.sv
module wdog_rst_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 2;
  localparam int RST_LEN    = 3;
  localparam int P          = 8;          // tick period in clocks
  localparam int HP         = 4;          // half-tick period in clocks
  localparam int H          = 2 ** (CNT_W - 1);
  localparam logic [7:0] CLR = 8'h26;
  localparam logic [7:0] STA = 8'hFF;

  logic clk = 1'b0;
  logic rst_n;
  logic tick, half;
  logic wr_en;
  logic [7:0] wr_addr, wr_data;
  logic sys_rst, cause, aclr;

  int total = 0;
  int bad   = 0;
  bit cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_rst_gen #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_wdog_rst_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .half_tick_i  (half),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .sys_rst_o    (sys_rst),
    .cause_flag_o (cause),
    .addr_clr_o   (aclr)
  );

  // behavioural reference model
  int m_sc, m_cnt, m_hc;
  bit m_act, m_cause, m_clr;
  always @(posedge clk or negedge rst_n) begin
    bit hold, wclr, wst, fire, ncause;
    if (!rst_n) begin
      m_sc = 0; m_cnt = 0; m_hc = 0; m_act = 0; m_cause = 0; m_clr = 0;
    end else if (m_sc < 2) begin
      m_sc++;
    end else begin
      hold   = m_act;
      wclr   = wr_en && wr_addr == CLR && !hold;
      wst    = wr_en && wr_addr == STA && !hold;
      fire   = !hold && !wclr && tick && (m_cnt == H - 1);   // R10: clear beats tick
      ncause = fire ? 1'b1 : (wst ? wr_data[6] : m_cause);
      if (hold) begin
        if (half) begin
          if (m_hc == RST_LEN - 1) m_act = 0;
          else m_hc++;
        end
      end else if (fire) begin
        m_act = 1; m_hc = 0;
      end
      if (hold || wclr || fire) m_cnt = 0;
      else if (tick) m_cnt = (m_cnt + 1) % (2 * H);
      m_cause = ncause;
      m_clr   = fire;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  initial forever begin
    @(negedge clk);
    if (cmp_en && rst_n) begin
      chk(sys_rst == m_act, "R3 R5 R8 R10 sys_rst", sys_rst, m_act);
      chk(cause == m_cause, "R6 R9 cause", cause, m_cause);
      chk(aclr == m_clr, "R7 addr_clr", aclr, m_clr);
    end
  end

  // strobe generator
  initial begin
    int ph = 0;
    tick = 0; half = 0;
    forever begin
      @(negedge clk);
      tick = (ph % P == 0);
      half = (ph % HP == 0);
      ph++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!sys_rst && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_fall(inout int w);
    while (sys_rst && w < 1000) begin
      @(negedge clk); w++;
      if (w == 1) chk(aclr == 0, "R7 pulse ends", aclr, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, w, i;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(sys_rst == 0, "R1 sys_rst in reset", sys_rst, 0);
    chk(cause == 0, "R1 cause in reset", cause, 0);
    chk(aclr == 0, "R1 addr_clr in reset", aclr, 0);
    @(negedge clk);
    rst_n = 1; cmp_en = 1;

    // A: unattended, fires; width and side effects
    wait_rise(n);
    chk(n > 0 && n <= H * P + 4, "R4 first fire", n, H * P);
    chk(cause == 1, "R6 flag at rise", cause, 1);
    chk(aclr == 1, "R7 pulse at rise", aclr, 1);
    w = 0; wait_fall(w);
    chk(w == RST_LEN * HP, "R5 width", w, RST_LEN * HP);

    // B: next reset, writes inside it are ignored (R8)
    wait_rise(n);
    wr(CLR, 8'h00);
    wr(STA, 8'h00);
    w = 4; wait_fall(w);
    chk(w == RST_LEN * HP, "R8 width with writes", w, RST_LEN * HP);
    chk(cause == 1, "R8 status write ignored", cause, 1);
    wait_rise(n);
    chk(n >= (H - 1) * P + 1 && n <= H * P, "R8 R4 restart from zero", n, H * P);
    w = 0; wait_fall(w);

    // C: regular clears keep it quiet (R2)
    begin
      bit seen = 0;
      for (int k = 0; k < 30; k++) begin
        wr(CLR, 8'(k * 37));
        if (sys_rst) seen = 1;
        repeat (4) begin @(negedge clk); if (sys_rst) seen = 1; end
      end
      chk(seen == 0, "R2 kept alive", seen, 0);
    end

    // D: status writes (R9)
    wr(CLR, 8'h5A);
    wr(STA, 8'hBF);
    chk(cause == 0, "R9 clear via bit6=0", cause, 0);
    wr(STA, 8'h40);
    chk(cause == 1, "R9 set via bit6=1", cause, 1);
    wr(STA, 8'h00);
    chk(cause == 0, "R9 clear again", cause, 0);

    // E: other addresses do not clear (R2 R4)
    wr(CLR, 8'hFF);
    i = 1;
    wr(8'h27, 8'hA5); wr(8'h25, 8'h00); wr(8'h00, 8'hFF);
    i += 6;
    while (!sys_rst && i < 1000) begin @(negedge clk); i++; end
    chk(i - 1 >= (H - 1) * P + 1 && i - 1 <= H * P, "R2 R4 window after clear", i - 1, H * P);
    chk(cause == 1, "R6 set after firmware clear", cause, 1);
    w = 0; wait_fall(w);

    // F: sticky across a second reset (R6)
    wait_rise(n);
    w = 0; wait_fall(w);
    chk(cause == 1, "R6 sticky", cause, 1);

    // G: power-on reset clears the flag (R1)
    @(negedge clk);
    cmp_en = 0; rst_n = 0;
    #1;
    chk(cause == 0, "R1 flag cleared by rst_n", cause, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(sys_rst == 0 && cause == 0, "R1 after release", sys_rst, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule